// File: doc/BRIEF.md
# Per-pin edge interrupt controller

This block watches a byte-wide group of general-purpose input pins, of which only a fixed subset is live, and raises one shared interrupt request whenever an enabled live pin makes a transition in the direction chosen for it. Software configures the block through a small write port holding two byte registers. One register enables each pin individually. The other chooses, per pin, whether a low-to-high or a high-to-low transition counts.

Each live pin is first brought into the clock domain by a two-stage synchronizer. Its edge is found by comparing the synchronized level with the level one clock earlier. The qualified edges of all pins are OR-ed into a single sticky pending flag, which drives the request output until an acknowledge pulse clears it. A combinational debug readback port returns the stored configuration, so writes can be checked without touching any interrupt logic.

Top module: `pin_edge_irq`

## Requirements
- R1: A pin whose enable bit is 0 never sets the pending flag, whatever it does. A pin whose enable bit is 1 may set it.
- R2: Polarity bit 1 makes a pin react only to a low-to-high change. Polarity bit 0 makes it react only to a high-to-low change.
- R3: Only bit positions 0, 1, 2 and 7 are live, and pin 7 behaves like the others once it is enabled.
- R4: While rst_n is low, irq is 0 and both configuration registers read 0.
- R5: Register bits 3 to 6 are not stored and read back as 0, and pins 3 to 6 never affect irq.
- R6: Once the pending flag is set it holds until ack is high at a rising clock edge, and ack then clears it one cycle later. If a qualifying edge is seen in the same cycle as ack, the flag stays set.
- R7: A pin change applied just after rising edge 0 raises irq just after rising edge 3 and not earlier. Edges on several pins at once produce one shared request, and a single ack clears it.
- R8: Changing a polarity bit while the pin level is steady does not set the pending flag.
- R9: With wr_en high, wr_addr 0 writes the enable register and wr_addr 1 writes the polarity register. rd_addr uses the same codes to select what rd_data returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 enable, 1 polarity |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Debug readback select: 0 enable, 1 polarity |
| rd_data | output | 8 | Debug readback of the selected register |
| pin_in | input | 8 | Asynchronous pin levels (bits 0, 1, 2, 7 live) |
| ack | input | 1 | Clears the pending flag |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench samples irq one cycle before and exactly at the expected latency. A synchronizer that is too short or too long therefore shows up as an early or late request. It drives transitions of the wrong direction, transitions on disabled pins and on the dead positions 3 to 6, and polarity flips while a pin is held high. A design that decodes polarity backwards, ignores the mask, or derives edges from the configuration would raise a spurious request. The bench also lands an acknowledge on the very cycle a fresh edge is detected, where a design that lets the clear win would drop the interrupt.

// File: rtl/pin_edge_irq_pkg.sv
// Package: shared widths, live-pin mask and register select codes for
// the per-pin edge interrupt controller.
package pin_edge_irq_pkg;
    localparam int unsigned PIN_W = 8;
    localparam logic [PIN_W-1:0] LIVE_MASK_DEF = 8'h87;

    typedef logic [PIN_W-1:0] pin_vec_t;

    typedef enum logic {
        SEL_ENABLE   = 1'b0,
        SEL_POLARITY = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/pin_edge_irq_sync.sv
// Module: multi-stage level synchronizer for one asynchronous input.
// Assumes the input is a slow level; clears to 0 on reset.
module pin_edge_irq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pin_edge_irq_edge.sv
// Module: per-pin edge qualifier. Synchronizes the pin, keeps one cycle of
// history and flags an edge of the selected direction when enabled.
// Assumes en and pol are stable register outputs; the edge depends only on
// the pin history, so a polarity change alone never produces a hit.
module pin_edge_irq_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    input  logic en,
    input  logic pol,
    output logic lvl_now,
    output logic lvl_prev,
    output logic hit
);
    logic rose;
    logic dropped;

    pin_edge_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pin_raw),
        .q_sync  (lvl_now)
    );

    // Remember the synchronized level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_prev <= 1'b0;
        end else begin
            lvl_prev <= lvl_now;
        end
    end

    // Decode direction of change and qualify by polarity and enable.
    always_comb begin
        rose    = lvl_now & ~lvl_prev;
        dropped = ~lvl_now & lvl_prev;
        hit     = en & (pol ? rose : dropped);
    end
endmodule

// File: rtl/pin_edge_irq_cfg.sv
// Module: enable and polarity configuration registers with a debug
// readback. Only bits set in LIVE_MASK are stored; others read as 0.
module pin_edge_irq_cfg
    import pin_edge_irq_pkg::*;
#(
    parameter int unsigned       W         = PIN_W,
    parameter logic [W-1:0]      LIVE_MASK = LIVE_MASK_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         rd_addr,
    output logic [W-1:0] rd_data,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pol_q
);
    // Capture writes into the addressed register, masked to live bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
        end else if (wr_en) begin
            if (reg_sel_e'(wr_addr) == SEL_ENABLE) begin
                en_q <= wr_data & LIVE_MASK;
            end else begin
                pol_q <= wr_data & LIVE_MASK;
            end
        end
    end

    // Select the register shown on the debug readback.
    always_comb begin
        rd_data = (reg_sel_e'(rd_addr) == SEL_ENABLE) ? en_q : pol_q;
    end
endmodule

// File: rtl/pin_edge_irq_pending.sv
// Module: sticky shared pending flag. Any hit sets it, ack clears it,
// and a hit in the same cycle as ack wins.
module pin_edge_irq_pending #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hits,
    input  logic         ack,
    output logic         any_hit,
    output logic         pending
);
    // Merge all per-pin hits into one request.
    always_comb begin
        any_hit = |hits;
    end

    // Hold the flag, giving a new hit priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (any_hit) begin
            pending <= 1'b1;
        end else if (ack) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/pin_edge_irq.sv
// Module: top of the per-pin edge interrupt controller. Instantiates an
// edge qualifier for every live bit position, the configuration registers
// and the shared pending flag. Assumes pin_in is asynchronous to clk.
module pin_edge_irq
    import pin_edge_irq_pkg::*;
#(
    parameter int unsigned        W           = PIN_W,
    parameter logic [W-1:0]       LIVE_MASK   = LIVE_MASK_DEF,
    parameter int unsigned        SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         rd_addr,
    output logic [W-1:0] rd_data,
    input  logic [W-1:0] pin_in,
    input  logic         ack,
    output logic         irq
);
    logic [W-1:0] en_q;
    logic [W-1:0] pol_q;
    logic [W-1:0] hit_vec;
    logic [W-1:0] lvl_vec;
    logic [W-1:0] hist_vec;
    logic         hit_any;
    logic         unused_pins;

    assign unused_pins = ^(pin_in & ~LIVE_MASK);

    pin_edge_irq_cfg #(.W(W), .LIVE_MASK(LIVE_MASK)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .en_q    (en_q),
        .pol_q   (pol_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (LIVE_MASK[i]) begin : g_live
            pin_edge_irq_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_raw  (pin_in[i]),
                .en       (en_q[i]),
                .pol      (pol_q[i]),
                .lvl_now  (lvl_vec[i]),
                .lvl_prev (hist_vec[i]),
                .hit      (hit_vec[i])
            );
        end else begin : g_dead
            assign lvl_vec[i]  = 1'b0;
            assign hist_vec[i] = 1'b0;
            assign hit_vec[i]  = 1'b0;
        end
    end

    pin_edge_irq_pending #(.W(W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .hits    (hit_vec),
        .ack     (ack),
        .any_hit (hit_any),
        .pending (irq)
    );
endmodule

// File: rtl/pin_edge_irq_chk.sv
// Module: assertion checker for pin_edge_irq, attached with bind.
module pin_edge_irq_chk #(
    parameter int unsigned  W         = 8,
    parameter logic [W-1:0] LIVE_MASK = 8'h87
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ack,
    input logic         irq,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] en_q,
    input logic [W-1:0] hit_vec,
    input logic [W-1:0] lvl_vec,
    input logic [W-1:0] hist_vec,
    input logic         hit_any
);
    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ~en_q) == '0); // R1
    AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~LIVE_MASK) == '0); // R5
    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |=> irq); // R6
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit_any) |=> !irq); // R6
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && !hit_any) |=> (irq == $past(irq))); // R6
    AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_vec & ~(lvl_vec ^ hist_vec)) == '0); // R8
endmodule

bind pin_edge_irq pin_edge_irq_chk #(.W(W), .LIVE_MASK(LIVE_MASK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack      (ack),
    .irq      (irq),
    .rd_data  (rd_data),
    .en_q     (en_q),
    .hit_vec  (hit_vec),
    .lvl_vec  (lvl_vec),
    .hist_vec (hist_vec),
    .hit_any  (hit_any)
);

// File: tb/tb_pin_edge_irq.sv
module tb_pin_edge_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = 8'h00;
    logic       ack = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        string      tag;
        logic       irq_exp;
        logic       chk_rd;
        logic [7:0] rd_exp;
    } exp_t;
    exp_t sb[$];

    pin_edge_irq dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .ack     (ack),
        .irq     (irq)
    );

    always #10 clk = ~clk;

    // Monitor: compare outputs against queued expectations at falling edges.
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (irq !== e.irq_exp) begin
                n_fail++;
                $display("FAIL %s irq actual=%b expected=%b", e.tag, irq, e.irq_exp);
            end
            if (e.chk_rd) begin
                n_checks++;
                if (rd_data !== e.rd_exp) begin
                    n_fail++;
                    $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.rd_exp);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = sel; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        step(1);
        ack = 1'b0;
    endtask

    task automatic expect_irq(input string tag, input logic v);
        exp_t e;
        e.tag = tag; e.irq_exp = v; e.chk_rd = 1'b0; e.rd_exp = 8'h00;
        sb.push_back(e);
        @(negedge clk); #1;
    endtask

    task automatic expect_all(input string tag, input logic v,
                              input logic sel, input logic [7:0] rd);
        exp_t e;
        rd_addr = sel;
        e.tag = tag; e.irq_exp = v; e.chk_rd = 1'b1; e.rd_exp = rd;
        sb.push_back(e);
        @(negedge clk); #1;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    // Driver: stimulus sequence with expectations pushed to the scoreboard.
    initial begin
        step(3);
        expect_all("R4 reset enable", 1'b0, 1'b0, 8'h00);
        expect_all("R4 reset polarity", 1'b0, 1'b1, 8'h00);
        rst_n = 1'b1;
        step(1);

        // R9 addressing, R2 rising on pin 0, R7 latency
        wr(1'b0, 8'h01);
        wr(1'b1, 8'h01);
        expect_all("R9 enable write", 1'b0, 1'b0, 8'h01);
        expect_all("R9 polarity write", 1'b0, 1'b1, 8'h01);
        pin_in[0] = 1'b1;
        step(2);
        expect_irq("R7 not early", 1'b0);
        step(1);
        expect_irq("R7 R2 rising raises irq", 1'b1);
        step(4);
        expect_irq("R6 held without ack", 1'b1);
        pulse_ack();
        expect_irq("R6 ack clears", 1'b0);

        // R2 falling ignored under rising polarity
        pin_in[0] = 1'b0;
        step(4);
        expect_irq("R2 falling ignored when rising", 1'b0);

        // R2 falling polarity on pin 1
        wr(1'b0, 8'h03);
        pin_in[1] = 1'b1;
        step(4);
        expect_irq("R2 rising ignored when falling", 1'b0);
        pin_in[1] = 1'b0;
        step(3);
        expect_irq("R2 falling raises irq", 1'b1);
        pulse_ack();
        expect_irq("R6 ack clears pin1", 1'b0);

        // R1 disabled pin 7, then R3 enabled pin 7
        pin_in[7] = 1'b1;
        step(4);
        expect_irq("R1 disabled pin ignored", 1'b0);
        pin_in[7] = 1'b0;
        step(4);
        expect_irq("R1 disabled pin fall ignored", 1'b0);
        wr(1'b1, 8'h81);
        wr(1'b0, 8'h83);
        pin_in[7] = 1'b1;
        step(3);
        expect_irq("R3 pin 7 raises irq", 1'b1);
        pulse_ack();
        expect_irq("R3 ack after pin 7", 1'b0);

        // R5 dead bit positions
        wr(1'b0, 8'hFF);
        expect_all("R5 enable readback masked", 1'b0, 1'b0, 8'h87);
        wr(1'b1, 8'h78);
        expect_all("R5 polarity readback masked", 1'b0, 1'b1, 8'h00);
        pin_in[6:3] = 4'hF;
        step(4);
        expect_irq("R5 dead pins rising", 1'b0);
        pin_in[6:3] = 4'h0;
        step(4);
        expect_irq("R5 dead pins falling", 1'b0);

        // R8 polarity flips with pin 7 held high
        wr(1'b1, 8'h87);
        step(3);
        expect_irq("R8 polarity to rising", 1'b0);
        wr(1'b1, 8'h00);
        step(3);
        expect_irq("R8 polarity to falling", 1'b0);

        // R6 edge wins over a simultaneous ack
        wr(1'b1, 8'h87);
        pin_in[0] = 1'b1;
        step(3);
        expect_irq("R6 first edge sets", 1'b1);
        pin_in[1] = 1'b1;
        step(2);
        ack = 1'b1;
        step(1);
        ack = 1'b0;
        expect_irq("R6 edge beats ack", 1'b1);
        step(2);
        expect_irq("R6 still set after race", 1'b1);
        pulse_ack();
        expect_irq("R6 later ack clears", 1'b0);

        // R7 several pins at once share one request
        wr(1'b1, 8'h00);
        pin_in[2] = 1'b1;
        step(4);
        expect_irq("R2 pin 2 rising ignored", 1'b0);
        pin_in = 8'h00;
        step(3);
        expect_irq("R7 multi-pin shared irq", 1'b1);
        pulse_ack();
        expect_irq("R7 single ack clears all", 1'b0);
        step(4);
        expect_irq("R7 no second request", 1'b0);

        // R4 reset mid-run clears flag and registers
        pin_in[0] = 1'b1;
        step(4);
        pin_in[0] = 1'b0;
        step(3);
        expect_irq("R4 pre-reset irq set", 1'b1);
        rst_n = 1'b0;
        step(1);
        expect_all("R4 reset clears enable", 1'b0, 1'b0, 8'h00);
        expect_all("R4 reset clears polarity", 1'b0, 1'b1, 8'h00);
        rst_n = 1'b1;
        step(2);
        summary();
    end
endmodule